// File: doc/BRIEF.md
# Shadow Memory Region Router

This block sits on the CPU memory path for the legacy upper area, 0xC0000 to 0xFFFFF. Each request is sent either to the ROM port or to the shadow RAM port. The choice comes from a 2-bit attribute field that belongs to the addressed region. The fields are packed into seven configuration bytes at offsets 0x59 through 0x5F, and a byte-write port updates those bytes.

A request is presented as an address, a write flag and a valid strobe. One clock later the block returns a route valid strobe with a RAM/ROM select. An error flag is raised instead when the address falls outside the decoded window.

Regions below 0xF0000 are 16 KB each and have one field apiece. The top 64 KB shares a single field. A read uses bit 0 of the field and a write uses bit 1, so the same field can give different routes for reads and writes.

Top module: `shadow_router`

## Requirements
- R1: `route_valid_o` is high exactly one cycle after a cycle with `req_valid_i` high, and low otherwise. While `route_valid_o` is low, `route_ram_o` and `route_err_o` are 0.
- R2: A request with an address below 0xC0000 or above 0xFFFFF (the address is 32 bits wide) gives `route_err_o`=1 and `route_ram_o`=0. A request inside the window gives `route_err_o`=0.
- R3: Address bits [19:14] pick the region. The 16 KB region n (n = 0..11, base 0xC0000 + n·0x4000) takes its field from byte 0x5A + n/2. Even n uses bits [1:0] of that byte and odd n uses bits [5:4].
- R4: Every address from 0xF0000 to 0xFFFFF takes its field from bits [5:4] of byte 0x59.
- R5: On a read (`req_write_i`=0), field bit 0 = 1 routes to shadow RAM (`route_ram_o`=1). Field bit 0 = 0 routes to ROM (`route_ram_o`=0).
- R6: On a write (`req_write_i`=1), field bit 1 = 1 routes to shadow RAM and field bit 1 = 0 routes to ROM.
- R7: After reset all seven attribute bytes are 0x00, so every in-window read and write routes to ROM.
- R8: A configuration write to an offset outside 0x59..0x5F changes no routing.
- R9: A configuration write takes effect for requests issued on the following cycle. A request issued in the same cycle as the write is routed with the old value.
- R10: Bits [3:2] and [7:6] of each attribute byte are stored but have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request byte address |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| cfg_we_i | input | 1 | Attribute byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Attribute byte data |
| route_valid_o | output | 1 | Routing decision valid |
| route_ram_o | output | 1 | 1 = shadow RAM, 0 = ROM |
| route_err_o | output | 1 | Request address outside the window |

## Verification
The hardest case to reach is a request issued in the same cycle as a write to the byte that controls it. The request must see the old value, and the very next request must see the new one. Directed sequences line up a configuration write and a request in one cycle, for both nibbles of a byte and for the shared top field. Random traffic then mixes configuration writes, including writes to offsets just outside the range and to the unused bits, with requests scattered across the window edges.

// File: rtl/shadow_router_pkg.sv
package shadow_router_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned CFG_AW     = 8;
  localparam int unsigned N_ATTR     = 7;
  localparam int unsigned FIRST_ATTR = 'h59;
  localparam int unsigned FIELD_W    = 2;

  typedef logic [7:0] attr_byte_t;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
  import shadow_router_pkg::*;
#(
  parameter int unsigned NBYTES = N_ATTR,
  parameter int unsigned BASE   = FIRST_ATTR,
  parameter int unsigned AW     = CFG_AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [7:0]             wdata_i,
  output logic [NBYTES-1:0][7:0] attr_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [AW-1:0] MyAddr = AW'(BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        attr_o[g] <= '0;
      else if (we_i && addr_i == MyAddr)  attr_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_router_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NBYTES = N_ATTR
) (
  input  logic [AW-1:14]         addr_hi_i,
  input  logic [NBYTES-1:0][7:0] attr_i,
  output logic                   in_win_o,
  output field_t                 field_o
);
  localparam int unsigned NSEG = 2 * (NBYTES - 1);

  logic [3:0] seg;
  assign seg = addr_hi_i[17:14];

  if (AW > 20) begin : g_hi
    assign in_win_o = (addr_hi_i[AW-1:20] == '0) && (addr_hi_i[19:18] == 2'b11);
  end else begin : g_lo
    assign in_win_o = (addr_hi_i[19:18] == 2'b11);
  end

  // per-segment field table, top region shares byte 0 upper nibble
  field_t seg_field [16];
  for (genvar s = 0; s < 16; s++) begin : g_seg
    if (s < NSEG) begin : g_own
      assign seg_field[s] = attr_i[1 + s/2][(s%2)*4 +: FIELD_W];
    end else begin : g_top
      assign seg_field[s] = attr_i[0][4 +: FIELD_W];
    end
  end

  assign field_o = seg_field[seg];
endmodule

// File: rtl/shadow_router.sv
module shadow_router
  import shadow_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic              route_valid_o,
  output logic              route_ram_o,
  output logic              route_err_o
);
  logic [N_ATTR-1:0][7:0] attr;
  logic                   in_win;
  field_t                 field;
  logic                   sel_ram;

  shadow_attr_regs #(.NBYTES(N_ATTR), .BASE(FIRST_ATTR), .AW(CFG_AW)) attr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .attr_o  (attr)
  );

  shadow_seg_decode #(.AW(ADDR_W), .NBYTES(N_ATTR)) dec_i (
    .addr_hi_i (req_addr_i[ADDR_W-1:14]),
    .attr_i    (attr),
    .in_win_o  (in_win),
    .field_o   (field)
  );

  // read enable is bit 0, write enable is bit 1
  assign sel_ram = req_write_i ? field[1] : field[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_valid_o <= 1'b0;
      route_ram_o   <= 1'b0;
      route_err_o   <= 1'b0;
    end else begin
      route_valid_o <= req_valid_i;
      route_ram_o   <= req_valid_i && in_win && sel_ram;
      route_err_o   <= req_valid_i && !in_win;
    end
  end
endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk
  import shadow_router_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic              route_valid_o,
  input logic              route_ram_o,
  input logic              route_err_o
);
  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> route_valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !route_valid_o);
  assert_quiet_outputs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> (!route_ram_o && !route_err_o));
  assert_err_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < 32'h000C_0000) |=> (route_err_o && !route_ram_o));
  assert_err_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i > 32'h000F_FFFF) |=> (route_err_o && !route_ram_o));
  assert_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i >= 32'h000C_0000 && req_addr_i <= 32'h000F_FFFF) |=> !route_err_o);
  assert_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({route_ram_o, route_err_o}));
endmodule

bind shadow_router shadow_router_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_write_i(req_write_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .route_valid_o(route_valid_o), .route_ram_o(route_ram_o),
  .route_err_o(route_err_o)
);

// File: tb/shadow_router_tb.sv
module shadow_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        route_valid_o, route_ram_o, route_err_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [7];

  always #5ns clk_i = ~clk_i;

  shadow_router dut_i (.*);

  function automatic logic exp_ram(input logic [31:0] a, input logic wr);
    logic [1:0] f;
    int s;
    if (a < 32'hC0000 || a > 32'hFFFFF) return 1'b0;
    s = int'(a[17:14]);
    if (s >= 12) f = mdl[0][5:4];
    else if (s % 2 == 1) f = mdl[1 + s/2][5:4];
    else f = mdl[1 + s/2][1:0];
    return wr ? f[1] : f[0];
  endfunction

  function automatic logic exp_err(input logic [31:0] a);
    return (a < 32'hC0000 || a > 32'hFFFFF);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: valid/ram/err act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic mdl_wr(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h59 && a <= 8'h5F) mdl[a - 8'h59] = d;
  endtask

  // drive at negedge, sample at next negedge
  task automatic req(input string tag, input logic [31:0] a, input logic wr);
    logic r, e;
    r = exp_ram(a, wr); e = exp_err(a);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(tag, {route_valid_o, route_ram_o, route_err_o}, {1'b1, r, e});
  endtask

  task automatic cfg(input logic [7:0] a, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    mdl_wr(a, d);
  endtask

  // request and config write in the same cycle
  task automatic req_cfg(input string tag, input logic [31:0] a, input logic wr,
                         input logic [7:0] ca, input logic [7:0] cd);
    logic r, e;
    r = exp_ram(a, wr); e = exp_err(a);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr;
    cfg_we_i = 1'b1; cfg_addr_i = ca; cfg_wdata_i = cd;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    mdl_wr(ca, cd);
    check(tag, {route_valid_o, route_ram_o, route_err_o}, {1'b1, r, e});
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog: act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", {route_valid_o, route_ram_o, route_err_o}, 3'b000);

    // R7: everything routes to ROM
    for (int s = 0; s < 16; s++) begin
      req("R7 reset read", 32'hC0000 + s * 32'h4000 + 32'h10, 1'b0);
      req("R7 reset write", 32'hC0000 + s * 32'h4000 + 32'h3FFF, 1'b1);
    end
    @(negedge clk_i);
    check("R1 valid drops", {route_valid_o, route_ram_o, route_err_o}, 3'b000);

    // R2 window edges
    req("R2 below", 32'hBFFFF, 1'b0);
    req("R2 base", 32'hC0000, 1'b0);
    req("R2 top", 32'hFFFFF, 1'b1);
    req("R2 above", 32'h100000, 1'b1);
    req("R2 far", 32'h800C0000, 1'b0);

    // R3/R5/R6: read-only RAM on even seg, write-only RAM on odd
    cfg(8'h5A, 8'h21);
    req("R3 R5 seg0 read", 32'hC0000, 1'b0);
    req("R3 R6 seg0 write", 32'hC3FFF, 1'b1);
    req("R3 R6 seg1 write", 32'hC4000, 1'b1);
    req("R3 R5 seg1 read", 32'hC7FFF, 1'b0);
    cfg(8'h5F, 8'h33);
    req("R3 seg11 read", 32'hEC000, 1'b0);
    req("R3 seg10 write", 32'hE8000, 1'b1);

    // R4: shared top field
    cfg(8'h59, 8'h30);
    req("R4 F0000 read", 32'hF0000, 1'b0);
    req("R4 FC000 write", 32'hFC123, 1'b1);
    cfg(8'h59, 8'h03);
    req("R4 low nibble ignored", 32'hF8000, 1'b0);

    // R10: unused bits
    cfg(8'h5C, 8'hCC);
    req("R10 seg4 read", 32'hD0000, 1'b0);
    req("R10 seg5 write", 32'hD4000, 1'b1);

    // R8: out-of-range offsets
    cfg(8'h58, 8'hFF);
    cfg(8'h60, 8'hFF);
    req("R8 F region", 32'hF4000, 1'b1);
    req("R8 seg6", 32'hD8000, 1'b0);

    // R9: same-cycle write sees old value, next sees new
    req_cfg("R9 same cycle", 32'hDC000, 1'b0, 8'h5D, 8'h10);
    req("R9 next cycle", 32'hDC000, 1'b0);
    req_cfg("R9 same cycle top", 32'hF0000, 1'b1, 8'h59, 8'h20);
    req("R9 next cycle top", 32'hF0000, 1'b1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 0)
          cfg(8'(8'h57 + $urandom_range(0, 10)), 8'($urandom));
        else
          req_cfg("R3 R5 R6 R9 random same", 32'hB0000 + $urandom_range(0, 32'h60000), 1'($urandom),
                  8'(8'h58 + $urandom_range(0, 8)), 8'($urandom));
      end else begin
        req("R3 R4 R5 R6 random", 32'hB0000 + $urandom_range(0, 32'h60000), 1'($urandom));
      end
    end

    @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule